// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory instruction issued for a whole warp and reduces its per-lane byte addresses to a short list of distinct segment requests. A start pulse captures the lane active mask, the lane addresses, an atomic flag and the configuration: the segment size as a power of two, the number of warp parts as a power of two, a broadcast-limit enable and a bank-selection mode. The block then processes one lane per clock. Each lane either joins an existing request or opens a new one.

Each request records four things: its segment address, the set of lanes it serves, a hit count for each quarter of the segment, and an issue order number. The order number comes from per-bank conflict counters, so that requests with equal order can go out together. Once the last lane is processed, one extra cycle ranks the requests by order, with ties kept in creation order. The block then pulses `done`. A downstream stage reads the sorted list through an index port. The result holds until the next accepted start.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `busy` and `done` are low and `ent_count` is 0.
- R2: The segment address of a lane is its address with the low `line_lg` bits cleared. With `line_lg` = 0, every distinct address gets its own request.
- R3: When a lane's segment matches a request, the lane's bit is set in that request's lane mask and the count for its quarter is incremented. A request's creating lane counts as 1 in its own quarter. The quarter is bits [line_lg-1:line_lg-2] of the address when `line_lg` ≥ 2, and 0 otherwise. Quarter k is read at `rd_qcnt[k*6 +: 6]`.
- R4: The lanes are split into 2^`part_lg` equal consecutive parts. A lane can match only requests created within its own part.
- R5: When `atomic_op` is set, every active lane opens its own request.
- R6: A lane whose `lane_active` bit is 0 creates and changes no request.
- R7: A new request takes its order from its bank's counter. If that counter is below the index of the first lane of the current part, the counter is first raised to that index. The counter then increments. All counters are cleared at start.
- R8: With `bank_sel` = 0, all requests use bank 0. With `bank_sel` = 1, the bank is address bits [3:2] (address word modulo 4 banks).
- R9: With `bcast_limit` = 1, a matched request takes a new order from a broadcast counter. That counter starts at the lane count (32) and is pre-incremented on each use. With `bcast_limit` = 0, a match leaves the order unchanged.
- R10: For k < `ent_count`, `rd_idx` = k returns the request with the k-th smallest order. Requests with equal order appear in creation order.
- R11: `done` is a one-cycle pulse 33 clocks after the edge that accepts `start`. `busy` is high in between, and a `start` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture an instruction and begin |
| lane_active | input | 32 | Active mask, bit per lane |
| lane_addr | input | 1024 | Lane l address at [l*32 +: 32] |
| atomic_op | input | 1 | Instruction is atomic |
| line_lg | input | 3 | log2 of segment size in bytes |
| part_lg | input | 2 | log2 of number of warp parts |
| bcast_limit | input | 1 | Give repeated segments their own order |
| bank_sel | input | 1 | 0 single bank, 1 word-interleaved banks |
| rd_idx | input | 5 | Sorted list position to read |
| busy | output | 1 | Walk or sort in progress |
| done | output | 1 | One-cycle completion pulse |
| ent_count | output | 6 | Number of requests built |
| rd_tag | output | 32 | Segment address at `rd_idx` |
| rd_lanes | output | 32 | Lane mask at `rd_idx` |
| rd_qcnt | output | 24 | Four 6-bit quarter counts at `rd_idx` |
| rd_order | output | 7 | Order number at `rd_idx` |

## Verification
A part-boundary pointer that advances at the wrong time shows up after `done` as too few requests or merged lane masks spanning two parts. A bank or broadcast counter that is off by one shows up as a shifted `rd_order`, and often as a permuted readout sequence. A wrong rank register swaps requests at `rd_idx`. All of these are visible on the first readout after the 33-cycle run, so each instruction is checked entry by entry against a model built from the requirements. Random mixes of masks, small address pools and configurations are combined with directed cases for full broadcast, atomics, parts and inactive lanes.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int QUARTERS = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_SORT = 2'd2
    } coal_state_e;

    // quarter of a segment hit by an address; segment size is 2**lg bytes
    function automatic logic [1:0] quarter_sel(input logic [9:0] low, input logic [2:0] lg);
        logic [9:0] sh;
        if (lg < 3'd2) return 2'd0;
        sh = low >> (lg - 3'd2);
        return sh[1:0];
    endfunction

endpackage

// File: rtl/coal_tag_match.sv
module coal_tag_match #(
    parameter int N      = 32,
    parameter int ADDR_W = 32,
    parameter int CW     = 6,
    parameter int IDX_W  = 5
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] tag,
    input  logic [N*ADDR_W-1:0] tags_flat,
    input  logic [CW-1:0]     lo,
    input  logic [CW-1:0]     hi,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx
);
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int j = N - 1; j >= 0; j--) begin
            if (en && (CW'(j) >= lo) && (CW'(j) < hi) &&
                (tags_flat[j*ADDR_W +: ADDR_W] == tag)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/coal_order_gen.sv
module coal_order_gen #(
    parameter int LANES = 32,
    parameter int NBANK = 4,
    parameter int OW    = 7,
    parameter int BW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          alloc,
    input  logic [BW-1:0] bank,
    input  logic [OW-1:0] part_start,
    input  logic          bcast_req,
    output logic [OW-1:0] alloc_order,
    output logic [OW-1:0] bcast_order
);
    logic [OW-1:0] bank_cnt_q [NBANK];
    logic [OW-1:0] bcast_q;

    always_comb begin
        alloc_order = (bank_cnt_q[bank] < part_start) ? part_start : bank_cnt_q[bank];
        bcast_order = bcast_q + OW'(1);
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    bank_cnt_q[b] <= '0;
                end else if (alloc && (bank == BW'(b))) begin
                    bank_cnt_q[b] <= alloc_order + OW'(1);
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bcast_q <= OW'(LANES);
        end else if (bcast_req) begin
            bcast_q <= bcast_q + OW'(1);
        end
    end

    // R9
    bcast_above_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        bcast_req |-> (bcast_order > OW'(LANES)));

    // R7
    alloc_not_below_part_chk: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (alloc_order >= part_start));

endmodule

// File: rtl/coal_rank.sv
module coal_rank #(
    parameter int N     = 32,
    parameter int OW    = 7,
    parameter int CW    = 6,
    parameter int IDX_W = 5
) (
    input  logic [N*OW-1:0]    ord_flat,
    input  logic [CW-1:0]      cnt,
    output logic [N*IDX_W-1:0] rank_flat
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_rank
            logic [IDX_W:0] r;
            always_comb begin
                r = '0;
                for (int j = 0; j < N; j++) begin
                    if ((CW'(j) < cnt) &&
                        ((ord_flat[j*OW +: OW] < ord_flat[i*OW +: OW]) ||
                         ((ord_flat[j*OW +: OW] == ord_flat[i*OW +: OW]) && (j < i)))) begin
                        r = r + (IDX_W+1)'(1);
                    end
                end
            end
            assign rank_flat[i*IDX_W +: IDX_W] = r[IDX_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int NBANK  = 4,
    parameter int PART_W = 2,
    localparam int IDX_W = $clog2(LANES),
    localparam int CW    = $clog2(LANES + 1),
    localparam int QW    = $clog2(LANES + 1),
    localparam int OW    = $clog2(2 * LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [LANES-1:0]        lane_active,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic                    atomic_op,
    input  logic [2:0]              line_lg,
    input  logic [PART_W-1:0]       part_lg,
    input  logic                    bcast_limit,
    input  logic                    bank_sel,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic                    busy,
    output logic                    done,
    output logic [CW-1:0]           ent_count,
    output logic [ADDR_W-1:0]       rd_tag,
    output logic [LANES-1:0]        rd_lanes,
    output logic [QUARTERS*QW-1:0]  rd_qcnt,
    output logic [OW-1:0]           rd_order
);
    localparam int BW = $clog2(NBANK);

    coal_state_e       state_q;
    logic [IDX_W-1:0]  lane_q;
    logic [LANES-1:0]  mask_q;
    logic [ADDR_W-1:0] addr_q [LANES];
    logic              atom_q;
    logic [2:0]        line_q;
    logic [PART_W-1:0] part_q;
    logic              bcl_q;
    logic              bsel_q;
    logic              done_q;

    logic [ADDR_W-1:0] ent_tag   [LANES];
    logic [LANES-1:0]  ent_lanes [LANES];
    logic [QW-1:0]     ent_q     [LANES][QUARTERS];
    logic [OW-1:0]     ent_order [LANES];
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     pbeg_q;
    logic [IDX_W-1:0]  rank_q    [LANES];

    logic accept;
    assign accept = start && (state_q == ST_IDLE);

    // current lane
    logic [ADDR_W-1:0] cur_addr, cur_tag;
    logic              cur_act, walking;
    logic [1:0]        cur_quarter;
    logic [IDX_W-1:0]  part_m1, part_start;
    logic              part_first;
    logic [CW-1:0]     pbeg_eff;
    logic [BW-1:0]     cur_bank;

    always_comb begin
        walking     = (state_q == ST_WALK);
        cur_addr    = addr_q[lane_q];
        cur_act     = mask_q[lane_q];
        cur_tag     = cur_addr & ({ADDR_W{1'b1}} << line_q);
        cur_quarter = quarter_sel(cur_addr[9:0], line_q);
        part_m1     = IDX_W'((LANES >> part_q) - 1);
        part_first  = ((lane_q & part_m1) == '0);
        part_start  = lane_q & ~part_m1;
        pbeg_eff    = part_first ? cnt_q : pbeg_q;
        cur_bank    = bsel_q ? cur_addr[2 +: BW] : '0;
    end

    // tag search over the current part
    logic [LANES*ADDR_W-1:0] tags_flat;
    always_comb begin
        for (int e = 0; e < LANES; e++) tags_flat[e*ADDR_W +: ADDR_W] = ent_tag[e];
    end

    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    coal_tag_match #(.N(LANES), .ADDR_W(ADDR_W), .CW(CW), .IDX_W(IDX_W)) u_match (
        .en       (walking && !atom_q),
        .tag      (cur_tag),
        .tags_flat(tags_flat),
        .lo       (pbeg_eff),
        .hi       (cnt_q),
        .hit      (hit),
        .hit_idx  (hit_idx)
    );

    logic new_ent, merge;
    assign new_ent = walking && cur_act && !hit;
    assign merge   = walking && cur_act && hit;

    logic [OW-1:0] alloc_order, bcast_order;

    coal_order_gen #(.LANES(LANES), .NBANK(NBANK), .OW(OW), .BW(BW)) u_order (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .alloc      (new_ent),
        .bank       (cur_bank),
        .part_start (OW'(part_start)),
        .bcast_req  (merge && bcl_q),
        .alloc_order(alloc_order),
        .bcast_order(bcast_order)
    );

    // control
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
            done_q  <= 1'b0;
            mask_q  <= '0;
            atom_q  <= 1'b0;
            line_q  <= '0;
            part_q  <= '0;
            bcl_q   <= 1'b0;
            bsel_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_WALK;
                    lane_q  <= '0;
                    mask_q  <= lane_active;
                    atom_q  <= atomic_op;
                    line_q  <= line_lg;
                    part_q  <= part_lg;
                    bcl_q   <= bcast_limit;
                    bsel_q  <= bank_sel;
                end
                ST_WALK: begin
                    lane_q <= lane_q + IDX_W'(1);
                    if (lane_q == IDX_W'(LANES - 1)) state_q <= ST_SORT;
                end
                ST_SORT: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int l = 0; l < LANES; l++) addr_q[l] <= lane_addr[l*ADDR_W +: ADDR_W];
        end
    end

    // request table
    always_ff @(posedge clk) begin
        if (rst || accept) begin
            cnt_q  <= '0;
            pbeg_q <= '0;
        end else if (walking) begin
            pbeg_q <= pbeg_eff;
            if (new_ent) begin
                ent_tag[cnt_q[IDX_W-1:0]]   <= cur_tag;
                ent_lanes[cnt_q[IDX_W-1:0]] <= LANES'(1) << lane_q;
                for (int k = 0; k < QUARTERS; k++) begin
                    ent_q[cnt_q[IDX_W-1:0]][k] <= (2'(k) == cur_quarter) ? QW'(1) : '0;
                end
                ent_order[cnt_q[IDX_W-1:0]] <= alloc_order;
                cnt_q <= cnt_q + CW'(1);
            end
            if (merge) begin
                ent_lanes[hit_idx] <= ent_lanes[hit_idx] | (LANES'(1) << lane_q);
                ent_q[hit_idx][cur_quarter] <= ent_q[hit_idx][cur_quarter] + QW'(1);
                if (bcl_q) ent_order[hit_idx] <= bcast_order;
            end
        end
    end

    // ranking
    logic [LANES*OW-1:0]    ord_flat;
    logic [LANES*IDX_W-1:0] rank_flat;
    always_comb begin
        for (int e = 0; e < LANES; e++) ord_flat[e*OW +: OW] = ent_order[e];
    end

    coal_rank #(.N(LANES), .OW(OW), .CW(CW), .IDX_W(IDX_W)) u_rank (
        .ord_flat (ord_flat),
        .cnt      (cnt_q),
        .rank_flat(rank_flat)
    );

    always_ff @(posedge clk) begin
        if (state_q == ST_SORT) begin
            for (int e = 0; e < LANES; e++) rank_q[e] <= rank_flat[e*IDX_W +: IDX_W];
        end
    end

    // sorted read port
    always_comb begin
        rd_tag   = '0;
        rd_lanes = '0;
        rd_qcnt  = '0;
        rd_order = '0;
        for (int e = 0; e < LANES; e++) begin
            if ((CW'(e) < cnt_q) && (rank_q[e] == rd_idx)) begin
                rd_tag   = ent_tag[e];
                rd_lanes = ent_lanes[e];
                rd_order = ent_order[e];
                for (int k = 0; k < QUARTERS; k++) rd_qcnt[k*QW +: QW] = ent_q[e][k];
            end
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign ent_count = cnt_q;

    // R11
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11
    done_after_sort_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (state_q == ST_IDLE) && !busy);

    // R5
    atomic_never_merges_chk: assert property (@(posedge clk) disable iff (rst)
        (walking && atom_q) |-> !hit);

    // R6
    inactive_lane_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (walking && !cur_act) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int AW = 32;
    localparam int QW = 6;
    localparam int OW = 7;

    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [LANES-1:0] lane_active;
    logic [LANES*AW-1:0] lane_addr;
    logic atomic_op, bcast_limit, bank_sel;
    logic [2:0] line_lg;
    logic [1:0] part_lg;
    logic [4:0] rd_idx;
    logic busy, done;
    logic [5:0] ent_count;
    logic [AW-1:0] rd_tag;
    logic [LANES-1:0] rd_lanes;
    logic [4*QW-1:0] rd_qcnt;
    logic [OW-1:0] rd_order;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_coalescer u_warp_coalescer (
        .clk(clk), .rst(rst), .start(start), .lane_active(lane_active),
        .lane_addr(lane_addr), .atomic_op(atomic_op), .line_lg(line_lg),
        .part_lg(part_lg), .bcast_limit(bcast_limit), .bank_sel(bank_sel),
        .rd_idx(rd_idx), .busy(busy), .done(done), .ent_count(ent_count),
        .rd_tag(rd_tag), .rd_lanes(rd_lanes), .rd_qcnt(rd_qcnt), .rd_order(rd_order)
    );

    int total = 0;
    int bad = 0;

    logic [AW-1:0] b_addr [LANES];
    logic [LANES-1:0] b_mask;
    logic b_atom, b_bcl, b_bsel;
    logic [2:0] b_line;
    logic [1:0] b_part;

    logic [AW-1:0] e_tag [LANES];
    logic [LANES-1:0] e_lanes [LANES];
    int e_q [LANES][4];
    int e_ord [LANES];
    int e_n;
    int srt [LANES];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model();
        int bc [4];
        int bo, pbeg, psize, q, hit, bk;
        logic [AW-1:0] tag;
        for (int b = 0; b < 4; b++) bc[b] = 0;
        bo = LANES; pbeg = 0; e_n = 0;
        psize = LANES >> b_part;
        for (int i = 0; i < LANES; i++) begin
            if (i % psize == 0) pbeg = e_n;
            if (!b_mask[i]) continue;
            tag = b_addr[i] & ({AW{1'b1}} << b_line);
            q = (b_line >= 2) ? int'((b_addr[i] >> (b_line - 2)) & 3) : 0;
            hit = -1;
            if (!b_atom) begin
                for (int j = pbeg; j < e_n; j++) if (hit < 0 && e_tag[j] == tag) hit = j;
            end
            if (hit >= 0) begin
                e_lanes[hit][i] = 1'b1;
                e_q[hit][q]++;
                if (b_bcl) begin bo++; e_ord[hit] = bo; end
            end else begin
                bk = b_bsel ? int'(b_addr[i][3:2]) : 0;
                if (bc[bk] < i - (i % psize)) bc[bk] = i - (i % psize);
                e_tag[e_n] = tag;
                e_lanes[e_n] = '0; e_lanes[e_n][i] = 1'b1;
                for (int k = 0; k < 4; k++) e_q[e_n][k] = (k == q) ? 1 : 0;
                e_ord[e_n] = bc[bk];
                bc[bk]++;
                e_n++;
            end
        end
        // stable sort of indices by order
        for (int i = 0; i < e_n; i++) srt[i] = i;
        for (int i = 1; i < e_n; i++) begin
            for (int j = i; j > 0; j--) begin
                if (e_ord[srt[j-1]] > e_ord[srt[j]]) begin
                    int t; t = srt[j]; srt[j] = srt[j-1]; srt[j-1] = t;
                end
            end
        end
    endtask

    task automatic drive_inputs();
        for (int l = 0; l < LANES; l++) lane_addr[l*AW +: AW] = b_addr[l];
        lane_active = b_mask; atomic_op = b_atom; line_lg = b_line;
        part_lg = b_part; bcast_limit = b_bcl; bank_sel = b_bsel;
    endtask

    // run one instruction; if poke is set, a second start with other data is sent mid-walk
    task automatic run(input string tname, input bit poke);
        int cyc;
        model();
        @(negedge clk);
        drive_inputs();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            if (poke && cyc == 5) begin
                start = 1'b1; lane_active = '1; atomic_op = 1'b1;
                for (int l = 0; l < LANES; l++) lane_addr[l*AW +: AW] = 32'h9000 + l * 64;
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        // R11: done after LANES+1 cycles
        chk(cyc == LANES + 1, {"R11 done timing ", tname}, cyc, LANES + 1);
        @(negedge clk);
        chk(!done && !busy, {"R11 single pulse ", tname}, {done, busy}, 0);
        // R2 R5 R6: request count
        chk(ent_count == e_n, {"R2/R5/R6 count ", tname}, ent_count, e_n);
        for (int k = 0; k < e_n; k++) begin
            bit ok;
            rd_idx = 5'(k);
            #1;
            ok = (rd_tag == e_tag[srt[k]]) && (rd_lanes == e_lanes[srt[k]]) &&
                 (rd_order == OW'(e_ord[srt[k]]));
            for (int q = 0; q < 4; q++) ok &= (rd_qcnt[q*QW +: QW] == QW'(e_q[srt[k]][q]));
            // R3 R4 R7 R8 R9 R10: entry contents in sorted position
            chk(ok, {"R3/R4/R7/R8/R9/R10 entry ", tname}, {rd_tag, rd_order},
                {e_tag[srt[k]], 7'(e_ord[srt[k]])});
        end
    endtask

    task automatic defaults();
        b_mask = '1; b_atom = 0; b_bcl = 0; b_bsel = 0; b_line = 3'd7; b_part = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; rd_idx = '0;
        lane_active = '0; lane_addr = '0; atomic_op = 0; line_lg = 0;
        part_lg = 0; bcast_limit = 0; bank_sel = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!busy && !done && ent_count == 0, "R1 reset state", {busy, done, ent_count}, 0);

        // R3: all lanes one segment, quarters by stride 4 bytes in 128B
        defaults();
        for (int l = 0; l < LANES; l++) b_addr[l] = 32'h1000 + l * 4;
        run("one_segment", 0);

        // R9: broadcast limit, all lanes same address
        defaults(); b_bcl = 1;
        for (int l = 0; l < LANES; l++) b_addr[l] = 32'h2040;
        run("broadcast", 0);

        // R5: atomics never merge
        defaults(); b_atom = 1;
        for (int l = 0; l < LANES; l++) b_addr[l] = 32'h3000;
        run("atomic", 0);

        // R4 R7: two parts, same address, second request raised to lane 16
        defaults(); b_part = 2'd1;
        for (int l = 0; l < LANES; l++) b_addr[l] = 32'h4000;
        run("two_parts", 0);

        // R6: half the lanes inactive
        defaults(); b_mask = 32'h0F0F_00FF; b_line = 3'd5;
        for (int l = 0; l < LANES; l++) b_addr[l] = 32'h5000 + l * 16;
        run("inactive", 0);

        // R2 R8: line 1 byte, interleaved banks
        defaults(); b_line = 3'd0; b_bsel = 1;
        for (int l = 0; l < LANES; l++) b_addr[l] = 32'h6000 + (l % 8) * 4;
        run("banks", 0);

        // R11: start while busy ignored
        defaults(); b_line = 3'd6;
        for (int l = 0; l < LANES; l++) b_addr[l] = 32'h7000 + l * 8;
        run("start_ignored", 1);

        // random mix
        for (int t = 0; t < 40; t++) begin
            logic [AW-1:0] pool [6];
            for (int p = 0; p < 6; p++) pool[p] = $urandom() & 32'h0000_FFFC;
            b_mask = $urandom();
            b_atom = ($urandom() % 8) == 0;
            b_bcl = $urandom() % 2;
            b_bsel = $urandom() % 2;
            b_line = 3'($urandom() % 8);
            b_part = 2'($urandom() % 3);
            for (int l = 0; l < LANES; l++) b_addr[l] = pool[$urandom() % 6] + ($urandom() % 4) * 4;
            run("random", 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule